// File: doc/BRIEF.md
# Card Response Capture Buffer

This block sits on the command line of a memory-card host. It waits for the card's answer after the host has sent a command and shifts that answer in serially. The host then reads the answer back as a run of 16-bit halfwords from a single read port. A 3-bit format code, given when the command goes out, selects one of three cases: no answer is expected, a 48-bit answer is expected, or a 136-bit answer is expected. For one of the 48-bit formats the checksum is not tested.

Sampling of the command line is paced by a bit strobe, one pulse per card clock. After a command, the block counts strobes until the start bit (a low level) arrives. If no start bit comes within a programmable number of strobes, it reports a missing answer. During the frame a serial 7-bit CRC is accumulated over the covered bits and then compared with the checksum field the card sent. Completion raises a sticky end-of-response status together with a one-cycle interrupt pulse.

Control is a three-state machine. The states are `ST_IDLE` (no frame expected or frame finished), `ST_WAIT` (counting strobes until a start bit) and `ST_RECV` (shifting frame bits). The transitions are:
- ISSUE: any state to `ST_WAIT` on a command with a valid format, or to `ST_IDLE` otherwise.
- START_SEEN: `ST_WAIT` to `ST_RECV`.
- NO_ANSWER: `ST_WAIT` to `ST_IDLE` when the timeout fires.
- FRAME_END: `ST_RECV` to `ST_IDLE` after the last frame bit.

Top module: `rsp_capture`

## Requirements
- R1: The format code `rsp_fmt` is latched on `cmd_issue`. Code 1 is a 48-bit frame with CRC check. Code 3 is a 48-bit frame without CRC check. Code 2 is a 136-bit frame with CRC check. Code 0 and codes 4 to 7 expect nothing: no status bit is ever set for them, and the line is ignored.
- R2: After a 48-bit frame f[47:0] (f[47] is the start bit, sent first), exactly three halfwords can be read: f[47:32], then f[31:16], then f[15:0].
- R3: After a 136-bit frame f[135:0], nine halfwords can be read from the same port. They are taken from {f, 8'h00}, highest 16 bits first, so the ninth halfword is {f[7:0], 8'h00}.
- R4: `rd_data` shows the current halfword combinationally, and each cycle with `rd_en` high pops one. When nothing is left (after reset, before a frame completes, or once all halfwords are read), `rd_data` is zero and a pop changes nothing.
- R5: On the clock edge that samples the last frame bit, `end_rsp` goes high and stays high, and `rsp_irq` goes high for exactly one cycle. The same happens when a timeout fires.
- R6: For codes 1 and 2, a serial CRC with polynomial x^7+x^3+1 and zero start value is run over the covered bits. For code 1 these are f[47:8]. For code 2 these are f[127:8]. If the result differs from f[7:1], `crc_err` is set together with `end_rsp`.
- R7: For code 3 the CRC field is not checked: `crc_err` stays low whatever the frame holds.
- R8: In `ST_WAIT`, if `to_limit` consecutive strobes all sample the line high, `rsp_timeout` and `end_rsp` are set and nothing becomes readable. A start bit seen on strobe number `to_limit` is still accepted.
- R9: `cmd_issue` clears `end_rsp`, `crc_err`, `rsp_timeout` and the readable halfwords in the next cycle. While it is high, strobes are ignored.
- R10: The line is sampled only in cycles where `bit_tick` is high. A low level without a strobe is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_issue | input | 1 | One-cycle pulse at the end of a sent command; starts a new capture |
| rsp_fmt | input | 3 | Response format code, sampled with `cmd_issue` |
| to_limit | input | TO_W | Number of strobes to wait for a start bit; 0 waits forever |
| bit_tick | input | 1 | Strobe: sample `cmd_line` in this cycle |
| cmd_line | input | 1 | Serial command line from the card (idle high) |
| rd_en | input | 1 | Pop one halfword from the read port |
| rd_data | output | RD_W | Current halfword, zero when empty |
| end_rsp | output | 1 | Sticky: frame received or timeout |
| rsp_irq | output | 1 | One-cycle pulse when `end_rsp` is raised |
| crc_err | output | 1 | Sticky: response CRC mismatch |
| rsp_timeout | output | 1 | Sticky: no start bit within `to_limit` strobes |

## Verification
A wrong state or bit counter shows at the ports within one frame. Either `end_rsp` rises on the wrong strobe, or the halfwords come out shifted by one bit, or `rsp_timeout` fires on the wrong count. All of these are visible in the cycle after the strobe where things go wrong. A wrong CRC register or a bad coverage window is only seen at the end of the frame, as a wrong `crc_err`. That is why both correct and corrupted checksums are sent for both frame lengths. A wrong read pointer is seen in the very next read, as a wrong or non-zero halfword.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } cap_state_t;

    localparam logic [2:0] FMT_NONE      = 3'd0;
    localparam logic [2:0] FMT_SHORT_CHK = 3'd1;
    localparam logic [2:0] FMT_LONG      = 3'd2;
    localparam logic [2:0] FMT_SHORT_RAW = 3'd3;

    function automatic logic fmt_expects(input logic [2:0] f);
        return (f == FMT_SHORT_CHK) || (f == FMT_LONG) || (f == FMT_SHORT_RAW);
    endfunction

    function automatic logic fmt_checked(input logic [2:0] f);
        return (f == FMT_SHORT_CHK) || (f == FMT_LONG);
    endfunction

endpackage

// File: rtl/rsp_cap_crc7.sv
module rsp_cap_crc7 #(
    parameter int               CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY  = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    logic fb;
    assign fb = din ^ crc[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

endmodule

// File: rtl/rsp_cap_store.sv
module rsp_cap_store #(
    parameter int RD_W       = 16,
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int CRC_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             load,
    input  logic             is_long,
    input  logic             rd_en,
    output logic [RD_W-1:0]  rd_data,
    output logic [CRC_W-1:0] rx_crc
);

    localparam int LONG_HW  = (LONG_BITS + RD_W - 1) / RD_W;
    localparam int SHORT_HW = (SHORT_BITS + RD_W - 1) / RD_W;
    localparam int VIEW_W   = LONG_HW * RD_W;
    localparam int PAD_L    = VIEW_W - LONG_BITS;
    localparam int PAD_S    = VIEW_W - SHORT_BITS;
    localparam int PTR_W    = $clog2(LONG_HW + 1);

    logic [LONG_BITS-1:0] sr;
    logic [PTR_W-1:0]     ptr;
    logic [PTR_W-1:0]     left;
    logic [VIEW_W-1:0]    view;
    logic [VIEW_W-1:0]    shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (clear) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[LONG_BITS-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            left <= '0;
        end else if (clear) begin
            ptr  <= '0;
            left <= '0;
        end else if (load) begin
            ptr  <= '0;
            left <= is_long ? PTR_W'(LONG_HW) : PTR_W'(SHORT_HW);
        end else if (rd_en && left != '0) begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
        end
    end

    always_comb begin
        if (is_long) view = {sr, {PAD_L{1'b0}}};
        else         view = {sr[SHORT_BITS-1:0], {PAD_S{1'b0}}};
        shifted = view << (RD_W * int'(ptr));
        rd_data = (left != '0) ? shifted[VIEW_W-1 -: RD_W] : '0;
    end

    assign rx_crc = sr[CRC_W-1:0];

endmodule

// File: rtl/rsp_cap_ctrl.sv
module rsp_cap_ctrl
    import rsp_cap_pkg::*;
#(
    parameter int TO_W       = 16,
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int LONG_SKIP  = 8,
    parameter int CRC_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_issue,
    input  logic [2:0]       rsp_fmt,
    input  logic [TO_W-1:0]  to_limit,
    input  logic             bit_tick,
    input  logic             cmd_line,
    input  logic [CRC_W-1:0] crc_calc,
    input  logic [CRC_W-1:0] rx_crc,
    output logic             shift_en,
    output logic             crc_en,
    output logic             frame_done,
    output logic             is_long,
    output logic             end_rsp,
    output logic             rsp_irq,
    output logic             crc_err,
    output logic             rsp_timeout
);

    localparam int TAIL  = CRC_W + 1;
    localparam int CNT_W = $clog2(LONG_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_S  = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_L  = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] COV_S_E = CNT_W'(SHORT_BITS - TAIL);
    localparam logic [CNT_W-1:0] COV_L_B = CNT_W'(LONG_SKIP);
    localparam logic [CNT_W-1:0] COV_L_E = CNT_W'(LONG_BITS - TAIL);

    cap_state_t       state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [TO_W-1:0]  to_cnt;
    logic             chk_q;
    logic             last_bit, covered, to_hit, to_fire;

    assign last_bit = bit_cnt == (is_long ? LAST_L : LAST_S);
    assign covered  = is_long ? (bit_cnt >= COV_L_B && bit_cnt < COV_L_E)
                              : (bit_cnt < COV_S_E);
    assign to_hit   = ({1'b0, to_cnt} + 1'b1) == {1'b0, to_limit};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: ISSUE, START_SEEN, NO_ANSWER, FRAME_END
    always_comb begin
        nxt = state;
        if (cmd_issue) begin
            nxt = fmt_expects(rsp_fmt) ? ST_WAIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_WAIT: begin
                    if (bit_tick && !cmd_line)         nxt = ST_RECV;
                    else if (bit_tick && to_hit)       nxt = ST_IDLE;
                end
                ST_RECV: if (bit_tick && last_bit)    nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // per-cycle strobes
    always_comb begin
        shift_en   = 1'b0;
        frame_done = 1'b0;
        to_fire    = 1'b0;
        if (!cmd_issue && bit_tick) begin
            unique case (state)
                ST_IDLE: ;
                ST_WAIT: begin
                    shift_en = !cmd_line;
                    to_fire  = cmd_line && to_hit;
                end
                ST_RECV: begin
                    shift_en   = 1'b1;
                    frame_done = last_bit;
                end
                default: ;
            endcase
        end
        crc_en = shift_en && covered;
    end

    // counters, latched format, status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            to_cnt      <= '0;
            is_long     <= 1'b0;
            chk_q       <= 1'b0;
            end_rsp     <= 1'b0;
            rsp_irq     <= 1'b0;
            crc_err     <= 1'b0;
            rsp_timeout <= 1'b0;
        end else if (cmd_issue) begin
            bit_cnt     <= '0;
            to_cnt      <= '0;
            is_long     <= rsp_fmt == FMT_LONG;
            chk_q       <= fmt_checked(rsp_fmt);
            end_rsp     <= 1'b0;
            rsp_irq     <= 1'b0;
            crc_err     <= 1'b0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_irq <= 1'b0;
            if (shift_en) bit_cnt <= bit_cnt + 1'b1;
            if (state == ST_WAIT && bit_tick && cmd_line) to_cnt <= to_cnt + 1'b1;
            if (frame_done) begin
                end_rsp <= 1'b1;
                rsp_irq <= 1'b1;
                crc_err <= chk_q && (crc_calc != rx_crc);
            end
            if (to_fire) begin
                end_rsp     <= 1'b1;
                rsp_irq     <= 1'b1;
                rsp_timeout <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsp_capture.sv
module rsp_capture #(
    parameter int RD_W       = 16,
    parameter int TO_W       = 16,
    parameter int SHORT_BITS = 48,
    parameter int LONG_BITS  = 136,
    parameter int LONG_SKIP  = 8,
    parameter int CRC_W      = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_issue,
    input  logic [2:0]      rsp_fmt,
    input  logic [TO_W-1:0] to_limit,
    input  logic            bit_tick,
    input  logic            cmd_line,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            end_rsp,
    output logic            rsp_irq,
    output logic            crc_err,
    output logic            rsp_timeout
);

    logic             shift_en, crc_en, frame_done, is_long;
    logic [CRC_W-1:0] crc_calc, rx_crc;

    rsp_cap_ctrl #(
        .TO_W(TO_W), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS),
        .LONG_SKIP(LONG_SKIP), .CRC_W(CRC_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .rsp_fmt(rsp_fmt),
        .to_limit(to_limit), .bit_tick(bit_tick), .cmd_line(cmd_line),
        .crc_calc(crc_calc), .rx_crc(rx_crc), .shift_en(shift_en),
        .crc_en(crc_en), .frame_done(frame_done), .is_long(is_long),
        .end_rsp(end_rsp), .rsp_irq(rsp_irq), .crc_err(crc_err),
        .rsp_timeout(rsp_timeout)
    );

    rsp_cap_crc7 #(.CRC_W(CRC_W), .POLY(CRC_W'(7'h09))) crc_i (
        .clk(clk), .rst_n(rst_n), .clr(cmd_issue), .en(crc_en),
        .din(cmd_line), .crc(crc_calc)
    );

    rsp_cap_store #(
        .RD_W(RD_W), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .CRC_W(CRC_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .clear(cmd_issue), .shift_en(shift_en),
        .bit_in(cmd_line), .load(frame_done), .is_long(is_long), .rd_en(rd_en),
        .rd_data(rd_data), .rx_crc(rx_crc)
    );

endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk #(
    parameter int RD_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_issue,
    input logic [RD_W-1:0] rd_data,
    input logic            end_rsp,
    input logic            rsp_irq,
    input logic            crc_err,
    input logic            rsp_timeout
);

    AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_irq |-> end_rsp); // R5
    AST_END_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_rsp) |-> rsp_irq); // R5
    AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (end_rsp && !cmd_issue) |=> end_rsp); // R5
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_irq |=> !rsp_irq); // R5
    AST_ERR_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err || rsp_timeout) |-> end_rsp); // R6
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_err && rsp_timeout)); // R8
    AST_TIMEOUT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rd_data == '0); // R8
    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> (!end_rsp && !crc_err && !rsp_timeout && rd_data == '0)); // R9

endmodule

bind rsp_capture rsp_capture_chk #(.RD_W(RD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .rd_data(rd_data),
    .end_rsp(end_rsp), .rsp_irq(rsp_irq), .crc_err(crc_err),
    .rsp_timeout(rsp_timeout)
);

// File: tb/rsp_capture_tb.sv
`timescale 1ns/1ps
module rsp_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_issue = 1'b0;
    logic [2:0]  rsp_fmt = 3'd0;
    logic [15:0] to_limit = 16'd1000;
    logic        bit_tick = 1'b0;
    logic        cmd_line = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        end_rsp, rsp_irq, crc_err, rsp_timeout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rsp_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .rsp_fmt(rsp_fmt),
        .to_limit(to_limit), .bit_tick(bit_tick), .cmd_line(cmd_line),
        .rd_en(rd_en), .rd_data(rd_data), .end_rsp(end_rsp), .rsp_irq(rsp_irq),
        .crc_err(crc_err), .rsp_timeout(rsp_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        logic fb;
        for (int i = hi; i >= lo; i--) begin
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] short_frame(input logic [31:0] arg, input logic bad);
        logic [39:0] head = {2'b00, 6'd17, arg};
        logic [6:0]  c = crc7({96'd0, head}, 39, 0);
        return {head, c ^ {6'd0, bad}, 1'b1};
    endfunction

    function automatic logic [135:0] long_frame(input logic [119:0] pl, input logic bad);
        logic [6:0] c = crc7({16'd0, pl}, 119, 0);
        return {8'h3F, pl, c ^ {6'd0, bad}, 1'b1};
    endfunction

    task automatic issue(input logic [2:0] f, input logic [15:0] lim);
        @(negedge clk);
        cmd_issue = 1'b1; rsp_fmt = f; to_limit = lim;
        @(negedge clk);
        cmd_issue = 1'b0;
    endtask

    task automatic tick(input logic b);
        @(negedge clk);
        cmd_line = b; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; cmd_line = 1'b1;
    endtask

    task automatic send(input logic [135:0] f, input int n);
        for (int i = n - 1; i >= 0; i--) tick(f[i]);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] exp);
        chk(tag, {16'd0, rd_data}, {16'd0, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R5 reset end_rsp", {31'd0, end_rsp}, 0);
        chk("R5 reset irq", {31'd0, rsp_irq}, 0);
        chk("R6 reset crc_err", {31'd0, crc_err}, 0);
        chk("R8 reset timeout", {31'd0, rsp_timeout}, 0);
        rd_chk("R4 empty after reset", 16'h0);
        rd_chk("R4 empty pop no move", 16'h0);
    endtask

    task automatic t_short_ok;
        logic [47:0] f = short_frame(32'hA5C3_0F96, 1'b0);
        issue(3'd1, 16'd1000);
        tick(1'b1); tick(1'b1);
        chk("R4 empty before frame", {16'd0, rd_data}, 0);
        send({88'd0, f}, 48);
        chk("R5 end on last bit", {31'd0, end_rsp}, 1);
        chk("R5 irq on last bit", {31'd0, rsp_irq}, 1);
        chk("R6 good crc short", {31'd0, crc_err}, 0);
        rd_chk("R2 hw0", f[47:32]);
        chk("R5 irq one cycle", {31'd0, rsp_irq}, 0);
        chk("R5 end sticky", {31'd0, end_rsp}, 1);
        rd_chk("R2 hw1", f[31:16]);
        rd_chk("R2 hw2", f[15:0]);
        rd_chk("R4 read past end", 16'h0);
        rd_chk("R4 read past end again", 16'h0);
    endtask

    task automatic t_short_bad;
        logic [47:0] f = short_frame(32'h1234_5678, 1'b1);
        issue(3'd1, 16'd1000);
        send({88'd0, f}, 48);
        chk("R6 bad crc short", {31'd0, crc_err}, 1);
        chk("R6 end with crc err", {31'd0, end_rsp}, 1);
        rd_chk("R2 hw0 with crc err", f[47:32]);
    endtask

    task automatic t_nocheck;
        logic [47:0] f = short_frame(32'h00FF_C0DE, 1'b1);
        issue(3'd3, 16'd1000);
        tick(1'b1);
        send({88'd0, f}, 48);
        chk("R7 no crc check", {31'd0, crc_err}, 0);
        chk("R7 end set", {31'd0, end_rsp}, 1);
        rd_chk("R7 hw0", f[47:32]);
        rd_chk("R7 hw1", f[31:16]);
        rd_chk("R7 hw2", f[15:0]);
        rd_chk("R7 past end", 16'h0);
    endtask

    task automatic t_long(input logic bad);
        logic [135:0] f = long_frame(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, bad);
        logic [143:0] v = {f, 8'h00};
        issue(3'd2, 16'd1000);
        tick(1'b1);
        send(f, 136);
        chk("R6 long crc", {31'd0, crc_err}, {31'd0, bad});
        chk("R5 long end", {31'd0, end_rsp}, 1);
        for (int k = 0; k < 9; k++) rd_chk("R3 long hw", v[143 - 16 * k -: 16]);
        rd_chk("R4 long past end", 16'h0);
    endtask

    task automatic t_timeout;
        issue(3'd1, 16'd5);
        for (int i = 0; i < 4; i++) tick(1'b1);
        chk("R8 no timeout before limit", {31'd0, rsp_timeout}, 0);
        chk("R8 no end before limit", {31'd0, end_rsp}, 0);
        tick(1'b1);
        chk("R8 timeout at limit", {31'd0, rsp_timeout}, 1);
        chk("R8 end at timeout", {31'd0, end_rsp}, 1);
        chk("R8 irq at timeout", {31'd0, rsp_irq}, 1);
        rd_chk("R8 nothing readable", 16'h0);
    endtask

    task automatic t_late_start;
        logic [47:0] f = short_frame(32'hCAFE_0001, 1'b0);
        issue(3'd1, 16'd5);
        for (int i = 0; i < 4; i++) tick(1'b1);
        send({88'd0, f}, 48);
        chk("R8 start on last strobe ok", {31'd0, rsp_timeout}, 0);
        chk("R8 late start end", {31'd0, end_rsp}, 1);
        rd_chk("R8 late start hw0", f[47:32]);
    endtask

    task automatic t_gating;
        issue(3'd1, 16'd5);
        @(negedge clk); cmd_line = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); cmd_line = 1'b1;
        for (int i = 0; i < 4; i++) tick(1'b1);
        chk("R10 low without strobe ignored", {31'd0, end_rsp}, 0);
        tick(1'b1);
        chk("R10 timeout count unchanged", {31'd0, rsp_timeout}, 1);
    endtask

    task automatic t_clear;
        logic [135:0] f = long_frame(120'h55AA, 1'b1);
        issue(3'd2, 16'd1000);
        send(f, 136);
        rd_chk("R3 pre-clear hw0", f[135:120]);
        issue(3'd1, 16'd1000);
        chk("R9 end cleared", {31'd0, end_rsp}, 0);
        chk("R9 crc cleared", {31'd0, crc_err}, 0);
        rd_chk("R9 buffer cleared", 16'h0);
    endtask

    task automatic t_none(input logic [2:0] f);
        issue(f, 16'd3);
        for (int i = 0; i < 60; i++) tick(1'b0);
        for (int i = 0; i < 6; i++) tick(1'b1);
        chk("R1 no end for none code", {31'd0, end_rsp}, 0);
        chk("R1 no timeout for none code", {31'd0, rsp_timeout}, 0);
        chk("R1 no crc_err for none code", {31'd0, crc_err}, 0);
        rd_chk("R1 nothing readable", 16'h0);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_ok();
        t_short_bad();
        t_nocheck();
        t_long(1'b0);
        t_long(1'b1);
        t_timeout();
        t_late_start();
        t_gating();
        t_clear();
        t_none(3'd0);
        t_none(3'd5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule